// File: doc/BRIEF.md
# Burst-Capable Synchronous Serial Master Port

This block is a clock-driving serial port that moves 8-bit words over a three-wire link: a serial clock it generates, a data output and a data input. A host loads one byte into a single holding register, sets the bit order, a clock divider and a burst length, and pulses start. The port then shifts out the loaded byte while sampling the input line, and keeps going byte after byte until the programmed number of bits has passed, anywhere from a single bit to 256 bits.

Between bytes the port checks whether the host has supplied the next byte. If it has, the next byte follows with no gap in the clock. If it has not, the port reports the finished byte, parks the clock at its idle high level and waits; writing the holding register resumes the transfer. When the burst length is not a multiple of eight, the last byte stops after the remaining bits and the bits received are right-aligned in the receive register.

Top module: `bsp_port`

## Requirements
- R1: After reset `sclk` and `sdo` are 1, `busy`, `byte_done` and `burst_done` are 0 and `rx_data` is 0.
- R2: Every low phase and every high phase of `sclk` inside a byte lasts `div_cfg`+2 cycles of `clk`; the divider value is taken at start.
- R3: `sdo` changes only in the cycle in which `sclk` falls, and `sdi` is captured at the rising edge of `sclk`.
- R4: With `msb_first`=1 bit 7 of each byte is sent first, descending; with `msb_first`=0 bit 0 is sent first, ascending. The order is taken at start.
- R5: A burst carries exactly `len_cfg`+1 bits (one `sclk` rising edge each); `burst_done` pulses for one cycle together with the last `byte_done`, and `busy` is 0 in that cycle.
- R6: When a byte ends with bits still to send and no byte has been written, `byte_done` pulses, `sclk` stays 1 and `busy` stays 1 until `wr_en`; the next byte then starts.
- R7: A byte written while the previous byte is still shifting follows it with no pause: the high phase across the byte boundary lasts `div_cfg`+2 cycles.
- R8: A write in the very cycle of a byte boundary is used at once: `sclk` falls at that same clock edge.
- R9: A final byte of n<8 bits stops after n bits; MSB-first sends bits 7 down to 8-n, LSB-first sends bits 0 to n-1; `rx_data` holds the n received bits in bits n-1..0, first received at bit n-1 for MSB-first and at bit 0 for LSB-first, upper bits 0.
- R10: A `start` pulse while `busy` is 1 is ignored: length, divider and order of the running burst are unchanged.
- R11: `rx_data` is updated only when `byte_done` pulses and then holds the whole byte received, first bit at bit 7 for MSB-first, at bit 0 for LSB-first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msb_first | input | 1 | 1: most significant bit first, 0: least significant bit first |
| div_cfg | input | 8 | Half bit period minus 2, in clk cycles |
| len_cfg | input | 8 | Burst length in bits minus one |
| start | input | 1 | Pulse to begin a burst when idle |
| wr_en | input | 1 | Write the holding register |
| wr_data | input | 8 | Byte to transmit next |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| rx_data | output | 8 | Last received byte, right-aligned |
| byte_done | output | 1 | One-cycle pulse when a byte completes |
| burst_done | output | 1 | One-cycle pulse when the burst completes |
| busy | output | 1 | Burst in progress |

## Verification
Two functions can land on the same clock edge: the end of a byte and a host write of the next byte, and the end of a byte and the end of the whole burst. The first is provoked by counting the rising serial clock edges of the current byte and raising `wr_en` exactly for the edge that closes its high phase; it is judged by seeing `sclk` low right after that edge instead of a pause. The second comes from burst lengths that are multiples of eight and from partial last bytes, and is judged by one cycle carrying both pulses, the correct bit count and the right-aligned received value.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    parameter int unsigned BSP_DATA_W = 8;
    parameter int unsigned BSP_DIV_W  = 8;
    parameter int unsigned BSP_LEN_W  = 8;

    localparam int unsigned BSP_IDX_W = $clog2(BSP_DATA_W);
    localparam int unsigned BSP_CNT_W = BSP_DIV_W + 1;
    localparam int unsigned BSP_REM_W = BSP_LEN_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LOW,
        ST_HIGH
    } bsp_state_e;

    typedef struct packed {
        bsp_state_e             state;
        logic [BSP_DATA_W-1:0]  hold;
        logic                   full;
        logic [BSP_DATA_W-1:0]  sh;
        logic [BSP_DATA_W-1:0]  rx;
        logic [BSP_DATA_W-1:0]  rx_out;
        logic [BSP_IDX_W-1:0]   idx;
        logic [BSP_REM_W-1:0]   remain;
        logic                   msb;
        logic [BSP_CNT_W-1:0]   half_m1;
        logic                   sclk;
        logic                   sdo;
        logic                   byte_done;
        logic                   burst_done;
    } bsp_regs_t;

endpackage

// File: rtl/bsp_baud.sv
module bsp_baud #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half_m1,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == half_m1);
        cnt_d = cnt_q + CNT_W'(1);
        if (!run || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/bsp_bitpick.sv
module bsp_bitpick #(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [W-1:0]     data,
    input  logic [IDX_W-1:0] idx,
    input  logic             msb_first,
    output logic             bit_out
);
    logic [W-1:0] rev;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = data[W-1-i];
    end

    always_comb begin
        bit_out = msb_first ? rev[idx] : data[idx];
    end
endmodule

// File: rtl/bsp_rxmerge.sv
module bsp_rxmerge #(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [W-1:0]     rx_in,
    input  logic [IDX_W-1:0] idx,
    input  logic             msb_first,
    input  logic             bit_in,
    output logic [W-1:0]     rx_out
);
    always_comb begin
        rx_out = rx_in;
        if (msb_first) begin
            rx_out = {rx_in[W-2:0], bit_in};
        end else begin
            rx_out[idx] = bit_in;
        end
    end
endmodule

// File: rtl/bsp_port.sv
module bsp_port
    import bsp_pkg::*;
#(
    parameter int unsigned MIN_HALF = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  msb_first,
    input  logic [BSP_DIV_W-1:0]  div_cfg,
    input  logic [BSP_LEN_W-1:0]  len_cfg,
    input  logic                  start,
    input  logic                  wr_en,
    input  logic [BSP_DATA_W-1:0] wr_data,
    input  logic                  sdi,
    output logic                  sclk,
    output logic                  sdo,
    output logic [BSP_DATA_W-1:0] rx_data,
    output logic                  byte_done,
    output logic                  burst_done,
    output logic                  busy
);
    localparam int unsigned W     = BSP_DATA_W;
    localparam int unsigned IDX_W = BSP_IDX_W;
    localparam int unsigned CNT_W = BSP_CNT_W;
    localparam int unsigned REM_W = BSP_REM_W;

    bsp_regs_t q, d;

    logic             tick;
    logic             run;
    logic             avail;
    logic [W-1:0]     next_byte;
    logic [IDX_W-1:0] idx_nxt;
    logic             bit_next;
    logic             bit_first;
    logic [W-1:0]     rx_merged;

    assign run       = (q.state == ST_LOW) || (q.state == ST_HIGH);
    assign avail     = q.full || wr_en;
    assign next_byte = wr_en ? wr_data : q.hold;
    assign idx_nxt   = q.idx + IDX_W'(1);

    bsp_baud #(.CNT_W(CNT_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .half_m1 (q.half_m1),
        .tick    (tick)
    );

    bsp_bitpick #(.W(W), .IDX_W(IDX_W)) u_pick_next (
        .data      (q.sh),
        .idx       (idx_nxt),
        .msb_first (q.msb),
        .bit_out   (bit_next)
    );

    bsp_bitpick #(.W(W), .IDX_W(IDX_W)) u_pick_first (
        .data      (next_byte),
        .idx       ('0),
        .msb_first (q.msb),
        .bit_out   (bit_first)
    );

    bsp_rxmerge #(.W(W), .IDX_W(IDX_W)) u_rx (
        .rx_in     (q.rx),
        .idx       (q.idx),
        .msb_first (q.msb),
        .bit_in    (sdi),
        .rx_out    (rx_merged)
    );

    always_comb begin
        d            = q;
        d.byte_done  = 1'b0;
        d.burst_done = 1'b0;

        if (wr_en) begin
            d.hold = wr_data;
            d.full = 1'b1;
        end

        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state   = ST_WAIT;
                    d.remain  = REM_W'(len_cfg) + REM_W'(1);
                    d.msb     = msb_first;
                    d.half_m1 = CNT_W'(div_cfg) + CNT_W'(MIN_HALF - 1);
                end
            end
            ST_WAIT: begin
                if (avail) begin
                    d.sh    = next_byte;
                    d.full  = 1'b0;
                    d.idx   = '0;
                    d.rx    = '0;
                    d.state = ST_LOW;
                    d.sclk  = 1'b0;
                    d.sdo   = bit_first;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    d.state  = ST_HIGH;
                    d.sclk   = 1'b1;
                    d.rx     = rx_merged;
                    d.remain = q.remain - REM_W'(1);
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (q.remain == '0) begin
                        d.byte_done  = 1'b1;
                        d.burst_done = 1'b1;
                        d.rx_out     = q.rx;
                        d.state      = ST_IDLE;
                    end else if (q.idx == IDX_W'(W - 1)) begin
                        d.byte_done = 1'b1;
                        d.rx_out    = q.rx;
                        if (avail) begin
                            d.sh    = next_byte;
                            d.full  = 1'b0;
                            d.idx   = '0;
                            d.rx    = '0;
                            d.state = ST_LOW;
                            d.sclk  = 1'b0;
                            d.sdo   = bit_first;
                        end else begin
                            d.state = ST_WAIT;
                        end
                    end else begin
                        d.idx   = idx_nxt;
                        d.state = ST_LOW;
                        d.sclk  = 1'b0;
                        d.sdo   = bit_next;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state      <= ST_IDLE;
            q.hold       <= '0;
            q.full       <= 1'b0;
            q.sh         <= '0;
            q.rx         <= '0;
            q.rx_out     <= '0;
            q.idx        <= '0;
            q.remain     <= '0;
            q.msb        <= 1'b0;
            q.half_m1    <= '0;
            q.sclk       <= 1'b1;
            q.sdo        <= 1'b1;
            q.byte_done  <= 1'b0;
            q.burst_done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sclk       = q.sclk;
    assign sdo        = q.sdo;
    assign rx_data    = q.rx_out;
    assign byte_done  = q.byte_done;
    assign burst_done = q.burst_done;
    assign busy       = (q.state != ST_IDLE);

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic sdo,
    input logic byte_done,
    input logic burst_done,
    input logic busy
);
    // R1: serial clock rests high whenever no burst runs
    a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);

    // R2: no phase is shorter than two system clocks
    a_r2_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |=> !sclk);
    a_r2_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && busy) |=> sclk);

    // R3: output data moves only together with a falling clock
    a_r3_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $fell(sclk));

    // R5: burst end comes with a byte end and leaves the port idle
    a_r5_burst_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> (byte_done && !busy));

    // R6: a byte can only finish out of a running burst
    a_r6_byte_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(busy));

    // R10: an accepted start makes the port busy
    a_r10_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

bind bsp_port bsp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sclk       (sclk),
    .sdo        (sdo),
    .byte_done  (byte_done),
    .burst_done (burst_done),
    .busy       (busy)
);

// File: tb/tb_bsp_port.sv
module tb_bsp_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       msb_first = 1'b0;
    logic [7:0] div_cfg = 8'd0;
    logic [7:0] len_cfg = 8'd0;
    logic       start = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       sdi = 1'b0;
    logic       sclk, sdo, byte_done, burst_done, busy;
    logic [7:0] rx_data;

    always #2.5 clk = ~clk;

    bsp_port dut (
        .clk(clk), .rst_n(rst_n), .msb_first(msb_first), .div_cfg(div_cfg),
        .len_cfg(len_cfg), .start(start), .wr_en(wr_en), .wr_data(wr_data),
        .sdi(sdi), .sclk(sclk), .sdo(sdo), .rx_data(rx_data),
        .byte_done(byte_done), .burst_done(burst_done), .busy(busy)
    );

    typedef struct {
        logic [7:0] tx;
        logic [7:0] rxs;
        int         n;
        bit         msb;
    } item_t;

    item_t itemq[$];
    item_t cur;

    int checks = 0;
    int fails = 0;
    int cur_h = 2;
    bit gapfree = 1'b0;
    int rises = 0;
    int bytes_seen = 0;
    int bursts_seen = 0;
    int exp_total = 0;
    int bit_i = 0;
    int lowcnt = 0;
    int highcnt = 0;
    logic prev_sclk = 1'b1;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_done) begin
                logic [7:0] exp_rx;
                if (cur.n == 8) exp_rx = cur.rxs;
                else if (cur.msb) exp_rx = cur.rxs >> (8 - cur.n);
                else exp_rx = cur.rxs & 8'((1 << cur.n) - 1);
                chk(bit_i == cur.n, "R9 bits per byte", bit_i, cur.n);
                chk(rx_data == exp_rx, "R11 rx_data", rx_data, exp_rx);
                bit_i = 0;
                bytes_seen++;
                if (burst_done) begin
                    chk(rises == exp_total, "R5 bit count", rises, exp_total);
                    chk(!busy, "R5 busy at burst end", busy, 0);
                    bursts_seen++;
                end
            end
            if (prev_sclk && !sclk) begin
                if (gapfree && rises > 0)
                    chk(highcnt == cur_h, "R7 high phase", highcnt, cur_h);
                if (bit_i == 0) begin
                    if (itemq.size() == 0) begin
                        chk(1'b0, "R5 unexpected byte", 0, 1);
                    end else begin
                        cur = itemq.pop_front();
                    end
                end
                sdi <= cur.msb ? cur.rxs[7 - bit_i] : cur.rxs[bit_i];
                highcnt = 0;
            end
            if (!prev_sclk && sclk) begin
                logic eb;
                eb = cur.msb ? cur.tx[7 - bit_i] : cur.tx[bit_i];
                chk(lowcnt == cur_h, "R2 low phase", lowcnt, cur_h);
                chk(sdo == eb, "R4 sdo bit", sdo, eb);
                bit_i++;
                rises++;
                lowcnt = 0;
            end
            if (!sclk) lowcnt++;
            else highcnt++;
            prev_sclk = sclk;
        end
    end

    function automatic logic [7:0] tx_of(int k, int seed);
        return 8'((k * 37 + seed * 11) ^ 8'hA5);
    endfunction
    function automatic logic [7:0] sx_of(int k, int seed);
        return 8'((k * 29 + seed * 7) ^ 8'h3C);
    endfunction

    task automatic write_byte(input logic [7:0] v);
        wr_data = v;
        wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    // mode 0: preload, 1: pause between bytes, 2: write on the boundary cycle
    task automatic run_burst(input bit msb, input int div, input int len,
                             input int mode, input bit restart, input int seed);
        int nb;
        int target;
        nb = (len + 8) / 8;
        for (int k = 0; k < nb; k++) begin
            item_t it;
            it.tx  = tx_of(k, seed);
            it.rxs = sx_of(k, seed);
            it.n   = (len + 1 - 8 * k >= 8) ? 8 : (len + 1 - 8 * k);
            it.msb = msb;
            itemq.push_back(it);
        end
        cur_h = div + 2;
        gapfree = (mode != 1);
        rises = 0;
        bytes_seen = 0;
        exp_total = len + 1;
        target = bursts_seen + 1;
        msb_first = msb;
        div_cfg = 8'(div);
        len_cfg = 8'(len);
        write_byte(tx_of(0, seed));
        start = 1'b1;
        step();
        start = 1'b0;
        for (int k = 1; k < nb; k++) begin
            if (mode == 0) begin
                if (k == 1) repeat (4) step();
                else while (bytes_seen < k - 1) step();
                write_byte(tx_of(k, seed));
                if (restart && k == 1) begin
                    len_cfg = 8'd0;
                    div_cfg = 8'd5;
                    msb_first = ~msb;
                    start = 1'b1;
                    step();
                    start = 1'b0;
                end
            end else if (mode == 1) begin
                while (bytes_seen < k) step();
                repeat (20) step();
                chk(sclk && busy, "R6 paused clock high", {sclk, busy}, 2'b11);
                chk(rises == 8 * k, "R6 no edges in pause", rises, 8 * k);
                write_byte(tx_of(k, seed));
            end else begin
                while (rises < 8 * k) step();
                repeat (cur_h - 1) step();
                wr_data = tx_of(k, seed);
                wr_en = 1'b1;
                step();
                wr_en = 1'b0;
                chk(!sclk && busy, "R8 boundary write used", {sclk, busy}, 2'b01);
            end
        end
        while (bursts_seen < target) step();
        chk(bytes_seen == nb, "R5 byte count", bytes_seen, nb);
        repeat (5) step();
        chk(sclk == 1'b1 && !busy, "R1 idle after burst", {sclk, busy}, 2'b10);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(sclk == 1'b1, "R1 sclk reset", sclk, 1);
        chk(sdo == 1'b1, "R1 sdo reset", sdo, 1);
        chk(!busy && !byte_done && !burst_done, "R1 flags reset",
            {busy, byte_done, burst_done}, 0);
        chk(rx_data == 8'd0, "R1 rx reset", rx_data, 0);

        run_burst(1'b1, 0, 15, 0, 1'b0, 1);   // R4 MSB, R7 preload
        run_burst(1'b0, 3, 11, 1, 1'b0, 2);   // R6 pause, R9 partial LSB
        run_burst(1'b1, 1, 4, 0, 1'b0, 3);    // R9 partial MSB
        run_burst(1'b0, 0, 0, 0, 1'b0, 4);    // R5 single bit
        run_burst(1'b1, 2, 23, 2, 1'b0, 5);   // R8 boundary writes
        run_burst(1'b0, 1, 19, 0, 1'b1, 6);   // R10 start while busy
        run_burst(1'b0, 0, 255, 0, 1'b0, 7);  // R5 256 bits
        run_burst(1'b1, 4, 13, 2, 1'b0, 8);   // R8 and R9 together

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule